// File: doc/BRIEF.md
# Thermostat Alert Generator

This block watches a stream of signed temperature samples and raises an alert when the temperature crosses programmable high and low limits. Each sample arrives with a one-cycle strobe. It is compared against the two limit words, and the result passes through a consecutive-fault filter before it can change the alert state. Two thermostat behaviours are available. In comparator mode the alert follows a hysteresis band between the two limits. In interrupt mode the alert is a latched event that software clears. Events alternate between the high limit and the low limit.

The alert pin polarity is programmable. A separate status bit always reports the hysteresis (comparator) state, whatever the thermostat mode. A source flag tells whether the active alert came from the high limit or from the low limit. The surrounding logic supplies the sample, the limits and the mode bits. It also supplies three strobes: one for a register read, one for a won alert-response arbitration, and the shutdown state.

Top module: `thermo_alert`

## Requirements
- R1: After reset the comparator state is idle, no interrupt event is pending, the limit-source state is "high", and all fault counters are zero. With polarity 0 this gives alertPin=1, alertStatus=1 and alertSource=0.
- R2: With extMode=1, samples and limits are compared as 13-bit two's complement values (1 LSB = 0.0625 °C). With extMode=0, only bits [11:0] are used, and bit 11 is the sign. For example, sample 13'h0A00 is +160 °C in 13-bit form and negative in 12-bit form.
- R3: faultSel selects how many consecutive qualifying samples are needed: 0 needs 1, 1 needs 2, 2 needs 4, 3 needs 6. A sample that does not meet the condition being sought resets that count to zero.
- R4: In comparator mode, an idle state becomes over-limit after the required count of samples at or above highLimit.
- R5: In comparator mode, the over-limit state returns to idle only after the required count of samples strictly below lowLimit. Samples between the limits, or equal to lowLimit, leave the state unchanged.
- R6: In interrupt mode, an event latches the alert. The latch is cleared by regRead, by respWon, or by the rising edge of shutdown. Samples are not counted while the latch is set. A new event in the same cycle as a clear keeps the latch set.
- R7: In interrupt mode, the first event needs samples at or above highLimit. Each event after that needs the opposite condition from the previous one: strictly below lowLimit, then at or above highLimit again, and so on. Leaving interrupt mode resets this sequence and the latch.
- R8: alertPin is active low when polarity=0 and active high when polarity=1. It reflects the comparator state in comparator mode and the interrupt latch in interrupt mode.
- R9: alertStatus reflects the comparator state in both modes: 1 when idle and 0 when over-limit with polarity=0, inverted with polarity=1.
- R10: With polarity 0, alertSource is 0 when the last state-changing event came from the high limit and 1 when it came from the low limit. With polarity 1 it is inverted. In interrupt mode only interrupt events update it.
- R11: Without a sample strobe, a clear strobe, a shutdown, or a change of mode or polarity, alertPin and alertStatus hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleData | input | 13 | Signed temperature sample |
| highLimit | input | 13 | Signed upper limit |
| lowLimit | input | 13 | Signed lower limit |
| extMode | input | 1 | 1: 13-bit format, 0: 12-bit format |
| intMode | input | 1 | 0: comparator mode, 1: interrupt mode |
| polarity | input | 1 | Alert pin and status polarity |
| faultSel | input | 2 | Consecutive-fault count select |
| regRead | input | 1 | Strobe: a register was read |
| respWon | input | 1 | Strobe: alert-response arbitration won |
| shutdown | input | 1 | Device is in shutdown |
| alertPin | output | 1 | Alert output level |
| alertStatus | output | 1 | Read-only comparator status bit |
| alertSource | output | 1 | Which limit caused the alert |

## Verification
On every cycle, the assertions check four things. In comparator mode, pin and status agree. Both outputs stay steady when no stimulus arrives. A single sample at or above the high limit (with a count of one) drives the status to over-limit. A read or a won response with no sample releases an interrupt alert. The bench scenarios cover the rest: fault-count sequences for every code, the reset of the count by a non-qualifying sample, the hysteresis band with its exact-limit values, the alternation of interrupt events, the source flag under both polarities, shutdown-entry clearing, and the 12-bit reinterpretation of the same sample word.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  // control -> datapath: which condition each counting lane is looking for
  typedef struct packed {
    logic cmpSeekLow;   // hysteresis lane wants samples below the low limit
    logic intSeekLow;   // event lane wants samples below the low limit
    logic intArmed;     // event lane may count (interrupt mode, nothing latched)
  } seek_t;

  // datapath -> control: qualified events, one-cycle strobes
  typedef struct packed {
    logic cmpHit;
    logic intHit;
  } hit_t;

  localparam int CNT_W = 3;

  // consecutive samples required for each queue code
  function automatic logic [CNT_W-1:0] faultNeed(input logic [1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = 3'd1;
      2'd1:    n = 3'd2;
      2'd2:    n = 3'd4;
      default: n = 3'd6;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/thermo_dp.sv
module thermo_dp
  import thermo_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleData,
  input  logic [TEMP_W-1:0] highLimit,
  input  logic [TEMP_W-1:0] lowLimit,
  input  logic              extMode,
  input  logic [1:0]        faultSel,
  input  seek_t             seek,
  output hit_t              hits
);

  localparam int LANES = 2;
  localparam int SUM_W = CNT_W + 1;

  // narrow format: drop the top bit and sign-extend from the next one
  function automatic logic signed [TEMP_W-1:0] fitFormat(
      input logic [TEMP_W-1:0] v, input logic wide);
    logic [TEMP_W-1:0] r;
    r = wide ? v : {v[TEMP_W-2], v[TEMP_W-2:0]};
    return signed'(r);
  endfunction

  logic signed [TEMP_W-1:0] sVal, hiVal, loVal;
  logic                     atOrAboveHigh, belowLow;
  logic [CNT_W-1:0]         need;

  always_comb begin
    sVal          = fitFormat(sampleData, extMode);
    hiVal         = fitFormat(highLimit, extMode);
    loVal         = fitFormat(lowLimit, extMode);
    atOrAboveHigh = (sVal >= hiVal);
    belowLow      = (sVal < loVal);
    need          = faultNeed(faultSel);
  end

  logic laneSeekLow [LANES];
  logic laneEn      [LANES];
  logic laneHit     [LANES];

  always_comb begin
    laneSeekLow[0] = seek.cmpSeekLow;
    laneEn[0]      = 1'b1;
    laneSeekLow[1] = seek.intSeekLow;
    laneEn[1]      = seek.intArmed;
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [CNT_W-1:0] cnt;
    logic             cond;
    logic             reach;

    always_comb begin
      cond  = laneSeekLow[gi] ? belowLow : atOrAboveHigh;
      reach = ({1'b0, cnt} + SUM_W'(1)) >= {1'b0, need};
      laneHit[gi] = laneEn[gi] && sampleValid && cond && reach;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (!laneEn[gi]) begin
        cnt <= '0;
      end else if (sampleValid) begin
        if (!cond || reach) cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    hits.cmpHit = laneHit[0];
    hits.intHit = laneHit[1];
  end

endmodule

// File: rtl/thermo_ctl.sv
module thermo_ctl
  import thermo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  hit_t  hits,
  input  logic  intMode,
  input  logic  polarity,
  input  logic  regRead,
  input  logic  respWon,
  input  logic  shutdown,
  output seek_t seek,
  output logic  alertPin,
  output logic  alertStatus,
  output logic  alertSource
);

  logic cmpOver;     // hysteresis state
  logic intPend;     // latched interrupt event
  logic intSeekLow;  // next interrupt event is a low-limit one
  logic srcLow;      // last relevant event came from the low limit
  logic sdPrev;
  logic clearReq;
  logic active;

  assign clearReq = regRead || respWon || (shutdown && !sdPrev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpOver    <= 1'b0;
      intPend    <= 1'b0;
      intSeekLow <= 1'b0;
      srcLow     <= 1'b0;
      sdPrev     <= 1'b0;
    end else begin
      sdPrev <= shutdown;
      if (hits.cmpHit) cmpOver <= !cmpOver;

      if (!intMode) begin
        intPend    <= 1'b0;
        intSeekLow <= 1'b0;
      end else if (hits.intHit) begin
        intPend    <= 1'b1;
        intSeekLow <= !intSeekLow;
      end else if (clearReq) begin
        intPend <= 1'b0;
      end

      if (intMode) begin
        if (hits.intHit) srcLow <= intSeekLow;
      end else begin
        if (hits.cmpHit) srcLow <= cmpOver;
      end
    end
  end

  always_comb begin
    seek.cmpSeekLow = cmpOver;
    seek.intSeekLow = intSeekLow;
    seek.intArmed   = intMode && !intPend;
    active          = intMode ? intPend : cmpOver;
    alertPin        = polarity ? active : !active;
    alertStatus     = polarity ? cmpOver : !cmpOver;
    alertSource     = srcLow ^ polarity;
  end

endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleData,
  input  logic [TEMP_W-1:0] highLimit,
  input  logic [TEMP_W-1:0] lowLimit,
  input  logic              extMode,
  input  logic              intMode,
  input  logic              polarity,
  input  logic [1:0]        faultSel,
  input  logic              regRead,
  input  logic              respWon,
  input  logic              shutdown,
  output logic              alertPin,
  output logic              alertStatus,
  output logic              alertSource
);

  seek_t seek;
  hit_t  hits;

  thermo_dp #(.TEMP_W(TEMP_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .highLimit  (highLimit),
    .lowLimit   (lowLimit),
    .extMode    (extMode),
    .faultSel   (faultSel),
    .seek       (seek),
    .hits       (hits)
  );

  thermo_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hits       (hits),
    .intMode    (intMode),
    .polarity   (polarity),
    .regRead    (regRead),
    .respWon    (respWon),
    .shutdown   (shutdown),
    .seek       (seek),
    .alertPin   (alertPin),
    .alertStatus(alertStatus),
    .alertSource(alertSource)
  );

endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk #(
  parameter int TEMP_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sampleValid,
  input logic [TEMP_W-1:0] sampleData,
  input logic [TEMP_W-1:0] highLimit,
  input logic [TEMP_W-1:0] lowLimit,
  input logic              extMode,
  input logic              intMode,
  input logic              polarity,
  input logic [1:0]        faultSel,
  input logic              regRead,
  input logic              respWon,
  input logic              shutdown,
  input logic              alertPin,
  input logic              alertStatus
);

  // R9
  pin_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intMode |-> (alertPin == alertStatus));

  // R11
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sampleValid) && !$past(regRead) && !$past(respWon) && !$past(shutdown)
     && $stable(polarity) && $stable(intMode)) |-> $stable(alertPin));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sampleValid) && $stable(polarity)) |-> $stable(alertStatus));

  // R4
  high_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && extMode && faultSel == 2'd0
     && $signed(highLimit) >= $signed(lowLimit)
     && $signed(sampleData) >= $signed(highLimit))
    |=> (alertStatus == polarity));

  // R6
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(regRead || respWon) && !$past(sampleValid) && $past(intMode) && intMode)
    |-> (alertPin == !polarity));

endmodule

bind thermo_alert thermo_alert_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sampleValid(sampleValid),
  .sampleData (sampleData),
  .highLimit  (highLimit),
  .lowLimit   (lowLimit),
  .extMode    (extMode),
  .intMode    (intMode),
  .polarity   (polarity),
  .faultSel   (faultSel),
  .regRead    (regRead),
  .respWon    (respWon),
  .shutdown   (shutdown),
  .alertPin   (alertPin),
  .alertStatus(alertStatus)
);

// File: tb/thermo_alert_test.sv
module thermo_alert_test;

  localparam int W = 13;
  localparam logic [W-1:0] TC  = 13'h0100;  // cold, below low limit
  localparam logic [W-1:0] TH  = 13'h0600;  // hot, above high limit
  localparam logic [W-1:0] TM  = 13'h04C0;  // inside the band
  localparam logic [W-1:0] THI = 13'h0500;  // +80 C, high limit
  localparam logic [W-1:0] TLO = 13'h04B0;  // +75 C, low limit
  localparam int NV = 41;

  // {valid, intMode, polarity, faultSel[1:0], regRead, data[12:0], exp {pin,status,source}}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,2'd0,1'b0,TC ,3'b110},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TH ,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TM ,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TC ,3'b111},
    {1'b1,1'b0,1'b0,2'd0,1'b0,THI,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TLO,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TC ,3'b111},
    {1'b1,1'b0,1'b0,2'd1,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd1,1'b0,TC ,3'b111},
    {1'b1,1'b0,1'b0,2'd1,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd1,1'b0,TH ,3'b000},
    {1'b1,1'b0,1'b0,2'd2,1'b0,TC ,3'b000},
    {1'b1,1'b0,1'b0,2'd2,1'b0,TC ,3'b000},
    {1'b1,1'b0,1'b0,2'd2,1'b0,TC ,3'b000},
    {1'b1,1'b0,1'b0,2'd2,1'b0,TC ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b0,2'd3,1'b0,TH ,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TC ,3'b111},
    {1'b0,1'b0,1'b1,2'd0,1'b0,TC ,3'b000},
    {1'b1,1'b0,1'b1,2'd0,1'b0,TH ,3'b111},
    {1'b1,1'b0,1'b1,2'd0,1'b0,TC ,3'b000},
    {1'b0,1'b1,1'b0,2'd0,1'b0,TC ,3'b111},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TH ,3'b000},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TH ,3'b000},
    {1'b0,1'b1,1'b0,2'd0,1'b1,TC ,3'b100},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TH ,3'b100},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TC ,3'b011},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TM ,3'b011},
    {1'b1,1'b1,1'b0,2'd0,1'b1,TH ,3'b101},
    {1'b1,1'b1,1'b0,2'd0,1'b0,TH ,3'b000},
    {1'b0,1'b1,1'b0,2'd0,1'b1,TC ,3'b100},
    {1'b1,1'b1,1'b1,2'd0,1'b0,TC ,3'b100},
    {1'b0,1'b1,1'b1,2'd0,1'b1,TC ,3'b000},
    {1'b1,1'b1,1'b0,2'd1,1'b0,TH ,3'b111},
    {1'b1,1'b1,1'b0,2'd1,1'b0,TH ,3'b000},
    {1'b0,1'b0,1'b0,2'd0,1'b0,TC ,3'b000},
    {1'b1,1'b0,1'b0,2'd0,1'b0,TC ,3'b111}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic sampleValid, extMode, intMode, polarity, regRead, respWon, shutdown;
  logic [W-1:0] sampleData, highLimit, lowLimit;
  logic [1:0] faultSel;
  logic alertPin, alertStatus, alertSource;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = !clk;

  thermo_alert #(.TEMP_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .highLimit(highLimit), .lowLimit(lowLimit), .extMode(extMode), .intMode(intMode),
    .polarity(polarity), .faultSel(faultSel), .regRead(regRead), .respWon(respWon),
    .shutdown(shutdown), .alertPin(alertPin), .alertStatus(alertStatus),
    .alertSource(alertSource)
  );

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {alertPin, alertStatus, alertSource};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {pin,status,source} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input int i);
    if (i < 7)       return "R4 R5 hysteresis";
    else if (i < 22) return "R3 fault queue";
    else if (i < 25) return "R8 R10 polarity";
    else if (i < 37) return "R6 R7 R9 R11 interrupt";
    else             return "R3 R7 mode switch";
  endfunction

  task automatic idleInputs();
    sampleValid = 1'b0; regRead = 1'b0; respWon = 1'b0; shutdown = 1'b0;
  endtask

  task automatic step(input logic v, input logic [W-1:0] d);
    sampleValid = v;
    sampleData  = d;
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    rst_n = 1'b0; idleInputs();
    sampleData = '0; highLimit = THI; lowLimit = TLO;
    extMode = 1'b1; intMode = 1'b0; polarity = 1'b0; faultSel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 3'b110);

    for (int i = 0; i < NV; i++) begin
      sampleValid = VEC[i][21];
      intMode     = VEC[i][20];
      polarity    = VEC[i][19];
      faultSel    = VEC[i][18:17];
      regRead     = VEC[i][16];
      sampleData  = VEC[i][15:3];
      @(negedge clk);
      check(tagOf(i), VEC[i][2:0]);
    end
    idleInputs();

    // R2: same word, 12-bit view is negative, 13-bit view is hot
    extMode = 1'b0; step(1'b1, 13'h0A00);
    check("R2 12-bit sign", 3'b111);
    extMode = 1'b1; step(1'b1, 13'h0A00);
    check("R2 13-bit value", 3'b000);
    step(1'b1, TC);
    check("R2 back to idle", 3'b111);

    // R6: clear by a won alert response
    intMode = 1'b1;
    step(1'b1, TH);
    check("R6 high event", 3'b000);
    respWon = 1'b1; @(negedge clk); idleInputs();
    check("R6 respWon clear", 3'b100);

    // R7 low event, then R6 clear on shutdown entry
    step(1'b1, TC);
    check("R7 low event", 3'b011);
    shutdown = 1'b1; @(negedge clk); shutdown = 1'b0;
    check("R6 shutdown clear", 3'b111);

    // R6: event and read in the same cycle, event survives
    regRead = 1'b1; step(1'b1, TH);
    check("R6 event beats read", 3'b000);
    regRead = 1'b1; @(negedge clk); idleInputs();
    check("R6 read clears", 3'b100);

    // R1: reset in mid-run
    intMode = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    check("R1 mid-run reset", 3'b110);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule